// File: doc/BRIEF.md
# BCD Calendar Clock

This block keeps wall-clock time and calendar date as seven two-digit packed BCD fields: seconds, minutes, hours (24-hour form), day of month, month, year (low two decimal digits) and day of week. It advances one second for every `TICK_DIV` accepted pulses on `tick_i`. The parameter lets a faster timebase be divided down inside the block. When `TICK_DIV` is 1, each pulse counts as one second.

A host drives three controls. `stop_i` freezes timekeeping. `set_i` copies the seven parallel BCD inputs into the fields. A rising edge on `comp_i` rounds the time to the nearest whole minute. Month length and February leap days are derived from the current month and the two-digit year. The day of week steps with every day rollover.

Each output byte carries its tens digit in bits 7:4 and its units digit in bits 3:0. Values loaded through `set_i` must be valid BCD within each field's range.

Top module: `bcd_rtc`

## Requirements
- R1: Seconds and minutes count 00..59 in BCD; at 59 the next advance gives 00 and carries into the next field.
- R2: Hours count 00..23; 23 followed by a carry gives 00 and starts a new day.
- R3: Day of month runs 01 up to the month length: 30 for months 04, 06, 09 and 11; 28 or 29 for month 02; 31 otherwise. It then returns to 01 and the month advances.
- R4: A year is a leap year when its two-digit value is divisible by 4, counting 00 as a leap year; February then has 29 days.
- R5: Month counts 01..12 and wraps to 01 while incrementing the year; year counts 00..99 and wraps to 00.
- R6: Day of week counts 00..06 (00 Sunday, 06 Saturday), advances once at each day rollover, and wraps 06 to 00.
- R7: While `stop_i` is high, tick pulses neither change any field nor advance the sub-second divider.
- R8: While `set_i` is high, all seven fields load from the `set_*_i` inputs on each clock, even when stopped. A load also clears the sub-second divider.
- R9: On a rising edge of `comp_i`, seconds of 30 or more clear to 00 and add one minute, with full carry through every field. Seconds below 30 simply clear to 00. Holding `comp_i` high has no further effect. The edge also clears the sub-second divider.
- R10: A field advance of one second happens on every `TICK_DIV`-th accepted tick pulse (here `TICK_DIV` = 2), counted from reset, load or compensation.
- R11: Outputs pack the tens digit in bits 7:4 and the units digit in bits 3:0. After reset the time is 00:00:00, date 01-01-00, and day of week 06.
- R12: In one cycle, a load beats a compensation edge, and a compensation edge beats a tick. The losing event is dropped.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| tick_i | input | 1 | Timebase pulse, one cycle wide |
| stop_i | input | 1 | Freeze timekeeping while high |
| set_i | input | 1 | Load all fields from the set inputs |
| comp_i | input | 1 | Round to nearest minute on rising edge |
| set_sec_i | input | 8 | BCD seconds to load |
| set_min_i | input | 8 | BCD minutes to load |
| set_hour_i | input | 8 | BCD hours to load |
| set_mday_i | input | 8 | BCD day of month to load |
| set_mon_i | input | 8 | BCD month to load |
| set_year_i | input | 8 | BCD year to load |
| set_wday_i | input | 8 | BCD day of week to load |
| sec_o | output | 8 | BCD seconds |
| min_o | output | 8 | BCD minutes |
| hour_o | output | 8 | BCD hours |
| mday_o | output | 8 | BCD day of month |
| mon_o | output | 8 | BCD month |
| year_o | output | 8 | BCD year |
| wday_o | output | 8 | BCD day of week |

## Verification
The bench drives the last day of every month and of February in leap and non-leap years, including year 00. A design with a wrong month table or a wrong divisibility rule would step into a 31st of April or skip 29 February. It rolls 31-12-99 23:59:59 into the next century, and it compensates at 23:59:30 on the same date. A broken carry chain would leave hours, the month, the year or the day of week stale. It also lines up coincident load, compensation and tick events, and checks that ticks stay frozen under stop and that the divider phase clears. Wrong priority, or a level-sensitive compensation, would round twice or leak a stray second.

// File: rtl/bcd_rtc_pkg.sv
package bcd_rtc_pkg;

   typedef logic [7:0] bcd2_t;

   localparam int NUM_FIELDS = 7;
   localparam int F_SEC  = 0;
   localparam int F_MIN  = 1;
   localparam int F_HOUR = 2;
   localparam int F_MDAY = 3;
   localparam int F_MON  = 4;
   localparam int F_YEAR = 5;
   localparam int F_WDAY = 6;

   typedef struct packed {
      bcd2_t year;
      bcd2_t mon;
      bcd2_t mday;
      bcd2_t wday;
      bcd2_t hour;
      bcd2_t min;
      bcd2_t sec;
   } rtc_time_t;

   // two-digit BCD increment, units digit wraps into the tens digit
   function automatic bcd2_t bcd2_inc(input bcd2_t v);
      if (v[3:0] >= 4'd9) return {v[7:4] + 4'd1, 4'd0};
      return {v[7:4], v[3:0] + 4'd1};
   endfunction

   // divisible by 4: even tens needs units 0/4/8, odd tens needs 2/6
   function automatic logic bcd2_is_leap(input bcd2_t yr);
      if (yr[4] == 1'b0)
         return (yr[3:0] == 4'd0) || (yr[3:0] == 4'd4) || (yr[3:0] == 4'd8);
      return (yr[3:0] == 4'd2) || (yr[3:0] == 4'd6);
   endfunction

   function automatic bcd2_t bcd2_month_len(input bcd2_t mon, input logic leap);
      case (mon)
         8'h02:                      return leap ? 8'h29 : 8'h28;
         8'h04, 8'h06, 8'h09, 8'h11: return 8'h30;
         default:                    return 8'h31;
      endcase
   endfunction

   function automatic bcd2_t field_min(input int idx);
      return (idx == F_MDAY || idx == F_MON) ? 8'h01 : 8'h00;
   endfunction

   function automatic bcd2_t field_rst(input int idx, input bcd2_t wday_rst);
      if (idx == F_WDAY) return wday_rst;
      return field_min(idx);
   endfunction

endpackage

// File: rtl/bcd_rtc_prescale.sv
module bcd_rtc_prescale #(
   parameter int TICK_DIV = 2
) (
   input  logic clk_i,
   input  logic rst_ni,
   input  logic tick_i,
   input  logic run_i,
   input  logic sync_clr_i,
   output logic sec_pulse_o
);
   localparam int CNT_W = (TICK_DIV > 1) ? $clog2(TICK_DIV) : 1;
   localparam logic [CNT_W-1:0] CNT_LAST = CNT_W'(TICK_DIV - 1);

   logic accept;
   assign accept = tick_i & run_i & ~sync_clr_i;

   generate
      if (TICK_DIV == 1) begin : g_direct
         assign sec_pulse_o = accept;
      end else begin : g_divide
         logic [CNT_W-1:0] cnt_q;
         always_ff @(posedge clk_i or negedge rst_ni) begin
            if (!rst_ni) begin
               cnt_q <= '0;
            end else if (sync_clr_i) begin
               cnt_q <= '0;
            end else if (accept) begin
               cnt_q <= (cnt_q == CNT_LAST) ? '0 : cnt_q + 1'b1;
            end
         end
         assign sec_pulse_o = accept & (cnt_q == CNT_LAST);
      end
   endgenerate

endmodule

// File: rtl/bcd_rtc_field.sv
module bcd_rtc_field
   import bcd_rtc_pkg::*;
#(
   parameter bcd2_t MIN_VAL = 8'h00,
   parameter bcd2_t RST_VAL = 8'h00
) (
   input  logic  clk_i,
   input  logic  rst_ni,
   input  logic  ld_i,
   input  bcd2_t ld_val_i,
   input  logic  clr_i,
   input  logic  inc_i,
   input  bcd2_t max_i,
   output bcd2_t q_o,
   output logic  top_o
);
   bcd2_t q;

   // ">=" so that an over-range day left by a month change still wraps
   assign top_o = (q >= max_i);
   assign q_o   = q;

   always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
         q <= RST_VAL;
      end else if (ld_i) begin
         q <= ld_val_i;
      end else if (clr_i) begin
         q <= MIN_VAL;
      end else if (inc_i) begin
         q <= top_o ? MIN_VAL : bcd2_inc(q);
      end
   end

endmodule

// File: rtl/bcd_rtc_core.sv
module bcd_rtc_core
   import bcd_rtc_pkg::*;
#(
   parameter bcd2_t WDAY_RST = 8'h06
) (
   input  logic      clk_i,
   input  logic      rst_ni,
   input  logic      sec_pulse_i,
   input  logic      comp_pulse_i,
   input  logic      load_i,
   input  rtc_time_t load_val_i,
   output rtc_time_t now_o
);
   bcd2_t                 fq   [NUM_FIELDS];
   bcd2_t                 fmax [NUM_FIELDS];
   bcd2_t                 fld  [NUM_FIELDS];
   logic [NUM_FIELDS-1:0] finc;
   logic [NUM_FIELDS-1:0] fclr;
   logic [NUM_FIELDS-1:0] ftop;

   logic adv_tick, do_comp, day_roll, comp_up;

   // priority: load, then compensation, then tick
   assign do_comp  = comp_pulse_i & ~load_i;
   assign adv_tick = sec_pulse_i & ~load_i & ~comp_pulse_i;
   assign comp_up  = do_comp & (fq[F_SEC] >= 8'h30);

   always_comb begin
      fld[F_SEC]  = load_val_i.sec;
      fld[F_MIN]  = load_val_i.min;
      fld[F_HOUR] = load_val_i.hour;
      fld[F_MDAY] = load_val_i.mday;
      fld[F_MON]  = load_val_i.mon;
      fld[F_YEAR] = load_val_i.year;
      fld[F_WDAY] = load_val_i.wday;
   end

   always_comb begin
      fmax[F_SEC]  = 8'h59;
      fmax[F_MIN]  = 8'h59;
      fmax[F_HOUR] = 8'h23;
      fmax[F_MDAY] = bcd2_month_len(fq[F_MON], bcd2_is_leap(fq[F_YEAR]));
      fmax[F_MON]  = 8'h12;
      fmax[F_YEAR] = 8'h99;
      fmax[F_WDAY] = 8'h06;
   end

   always_comb begin
      fclr         = '0;
      fclr[F_SEC]  = do_comp;
      finc         = '0;
      finc[F_SEC]  = adv_tick;
      finc[F_MIN]  = (adv_tick & ftop[F_SEC]) | comp_up;
      finc[F_HOUR] = finc[F_MIN] & ftop[F_MIN];
      day_roll     = finc[F_HOUR] & ftop[F_HOUR];
      finc[F_MDAY] = day_roll;
      finc[F_WDAY] = day_roll;
      finc[F_MON]  = day_roll & ftop[F_MDAY];
      finc[F_YEAR] = finc[F_MON] & ftop[F_MON];
   end

   generate
      for (genvar i = 0; i < NUM_FIELDS; i++) begin : g_field
         bcd_rtc_field #(
            .MIN_VAL (field_min(i)),
            .RST_VAL (field_rst(i, WDAY_RST))
         ) u_field (
            .clk_i    (clk_i),
            .rst_ni   (rst_ni),
            .ld_i     (load_i),
            .ld_val_i (fld[i]),
            .clr_i    (fclr[i]),
            .inc_i    (finc[i]),
            .max_i    (fmax[i]),
            .q_o      (fq[i]),
            .top_o    (ftop[i])
         );
      end
   endgenerate

   always_comb begin
      now_o.sec  = fq[F_SEC];
      now_o.min  = fq[F_MIN];
      now_o.hour = fq[F_HOUR];
      now_o.mday = fq[F_MDAY];
      now_o.mon  = fq[F_MON];
      now_o.year = fq[F_YEAR];
      now_o.wday = fq[F_WDAY];
   end

endmodule

// File: rtl/bcd_rtc.sv
module bcd_rtc
   import bcd_rtc_pkg::*;
#(
   parameter int    TICK_DIV = 2,
   parameter bcd2_t WDAY_RST = 8'h06
) (
   input  logic       clk_i,
   input  logic       rst_ni,
   input  logic       tick_i,
   input  logic       stop_i,
   input  logic       set_i,
   input  logic       comp_i,
   input  logic [7:0] set_sec_i,
   input  logic [7:0] set_min_i,
   input  logic [7:0] set_hour_i,
   input  logic [7:0] set_mday_i,
   input  logic [7:0] set_mon_i,
   input  logic [7:0] set_year_i,
   input  logic [7:0] set_wday_i,
   output logic [7:0] sec_o,
   output logic [7:0] min_o,
   output logic [7:0] hour_o,
   output logic [7:0] mday_o,
   output logic [7:0] mon_o,
   output logic [7:0] year_o,
   output logic [7:0] wday_o
);
   generate
      if (TICK_DIV < 1) begin : g_bad_div
         $error("bcd_rtc: TICK_DIV must be at least 1");
      end
      if (WDAY_RST > 8'h06) begin : g_bad_wday
         $error("bcd_rtc: WDAY_RST must lie in 00..06");
      end
   endgenerate

   logic      comp_q, comp_pulse, sec_pulse;
   rtc_time_t load_val, now;

   always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) comp_q <= 1'b0;
      else         comp_q <= comp_i;
   end
   assign comp_pulse = comp_i & ~comp_q;

   bcd_rtc_prescale #(.TICK_DIV(TICK_DIV)) u_prescale (
      .clk_i       (clk_i),
      .rst_ni      (rst_ni),
      .tick_i      (tick_i),
      .run_i       (~stop_i),
      .sync_clr_i  (set_i | comp_pulse),
      .sec_pulse_o (sec_pulse)
   );

   always_comb begin
      load_val.sec  = set_sec_i;
      load_val.min  = set_min_i;
      load_val.hour = set_hour_i;
      load_val.mday = set_mday_i;
      load_val.mon  = set_mon_i;
      load_val.year = set_year_i;
      load_val.wday = set_wday_i;
   end

   bcd_rtc_core #(.WDAY_RST(WDAY_RST)) u_core (
      .clk_i        (clk_i),
      .rst_ni       (rst_ni),
      .sec_pulse_i  (sec_pulse),
      .comp_pulse_i (comp_pulse),
      .load_i       (set_i),
      .load_val_i   (load_val),
      .now_o        (now)
   );

   assign sec_o  = now.sec;
   assign min_o  = now.min;
   assign hour_o = now.hour;
   assign mday_o = now.mday;
   assign mon_o  = now.mon;
   assign year_o = now.year;
   assign wday_o = now.wday;

endmodule

// File: rtl/bcd_rtc_chk.sv
module bcd_rtc_chk (
   input logic       clk_i,
   input logic       rst_ni,
   input logic       tick_i,
   input logic       stop_i,
   input logic       set_i,
   input logic       comp_i,
   input logic [7:0] set_sec_i,
   input logic [7:0] set_min_i,
   input logic [7:0] set_hour_i,
   input logic [7:0] set_mday_i,
   input logic [7:0] set_mon_i,
   input logic [7:0] set_year_i,
   input logic [7:0] set_wday_i,
   input logic [7:0] sec_o,
   input logic [7:0] min_o,
   input logic [7:0] hour_o,
   input logic [7:0] mday_o,
   input logic [7:0] mon_o,
   input logic [7:0] year_o,
   input logic [7:0] wday_o
);
   logic [55:0] now_v, set_v;
   assign now_v = {year_o, mon_o, mday_o, wday_o, hour_o, min_o, sec_o};
   assign set_v = {set_year_i, set_mon_i, set_mday_i, set_wday_i,
                   set_hour_i, set_min_i, set_sec_i};

   a_r1_sec_range: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (sec_o <= 8'h59) && (sec_o[3:0] <= 4'd9) && (min_o <= 8'h59));

   a_r6_wday_range: assert property (@(posedge clk_i) disable iff (!rst_ni)
      wday_o <= 8'h06);

   a_r7_stop_hold: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (stop_i && !set_i && !$rose(comp_i)) |=> $stable(now_v));

   a_r8_set_load: assert property (@(posedge clk_i) disable iff (!rst_ni)
      set_i |=> (now_v == $past(set_v)));

   a_r9_comp_clear: assert property (@(posedge clk_i) disable iff (!rst_ni)
      ($rose(comp_i) && !set_i) |=> (sec_o == 8'h00));

   a_r10_no_tick_hold: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (!tick_i && !set_i && !$rose(comp_i)) |=> $stable(now_v));

endmodule

bind bcd_rtc bcd_rtc_chk u_chk (
   .clk_i(clk_i), .rst_ni(rst_ni), .tick_i(tick_i), .stop_i(stop_i),
   .set_i(set_i), .comp_i(comp_i),
   .set_sec_i(set_sec_i), .set_min_i(set_min_i), .set_hour_i(set_hour_i),
   .set_mday_i(set_mday_i), .set_mon_i(set_mon_i), .set_year_i(set_year_i),
   .set_wday_i(set_wday_i),
   .sec_o(sec_o), .min_o(min_o), .hour_o(hour_o), .mday_o(mday_o),
   .mon_o(mon_o), .year_o(year_o), .wday_o(wday_o)
);

// File: tb/bcd_rtc_tb.sv
module bcd_rtc_tb;
   localparam int DIV = 2;

   logic clk = 1'b0;
   logic rst_n = 1'b0;
   logic tick = 1'b0, stop = 1'b0, set = 1'b0, comp = 1'b0;
   logic [7:0] s_sec = 0, s_min = 0, s_hour = 0, s_mday = 8'h01,
               s_mon = 8'h01, s_year = 0, s_wday = 0;
   logic [7:0] sec, min, hour, mday, mon, year, wday;
   int checks = 0;
   int fails  = 0;

   always #4 clk = ~clk;

   bcd_rtc #(.TICK_DIV(DIV)) u_dut (
      .clk_i(clk), .rst_ni(rst_n), .tick_i(tick), .stop_i(stop),
      .set_i(set), .comp_i(comp),
      .set_sec_i(s_sec), .set_min_i(s_min), .set_hour_i(s_hour),
      .set_mday_i(s_mday), .set_mon_i(s_mon), .set_year_i(s_year),
      .set_wday_i(s_wday),
      .sec_o(sec), .min_o(min), .hour_o(hour), .mday_o(mday),
      .mon_o(mon), .year_o(year), .wday_o(wday));

   // packed view: year mon mday wday hour min sec
   function automatic logic [55:0] tv(input logic [7:0] y, mo, d, w, h, mi, s);
      return {y, mo, d, w, h, mi, s};
   endfunction

   function automatic logic [7:0] to_bcd(input int v);
      return {4'(v / 10), 4'(v % 10)};
   endfunction

   function automatic int mlen(input int m, input int y);
      if (m == 2) return (y % 4 == 0) ? 29 : 28;
      if (m == 4 || m == 6 || m == 9 || m == 11) return 30;
      return 31;
   endfunction

   task automatic check(input string req, input logic [55:0] exp);
      logic [55:0] act;
      act = {year, mon, mday, wday, hour, min, sec};
      checks++;
      if (act !== exp) begin
         fails++;
         $display("FAIL %s actual=%h expected=%h", req, act, exp);
      end
   endtask

   task automatic tick_pulse();
      @(negedge clk); tick = 1'b1;
      @(negedge clk); tick = 1'b0;
   endtask

   task automatic one_second();
      for (int i = 0; i < DIV; i++) tick_pulse();
   endtask

   task automatic load(input logic [55:0] v);
      @(negedge clk);
      {s_year, s_mon, s_mday, s_wday, s_hour, s_min, s_sec} = v;
      set = 1'b1;
      @(negedge clk); set = 1'b0;
   endtask

   task automatic comp_edge();
      @(negedge clk); comp = 1'b1;
      @(negedge clk); comp = 1'b0;
   endtask

   task automatic t_reset();
      check("R11 reset state", tv(8'h00, 8'h01, 8'h01, 8'h06, 8'h00, 8'h00, 8'h00));
   endtask

   task automatic t_prescale();
      load(tv(8'h23, 8'h05, 8'h17, 8'h03, 8'h08, 8'h30, 8'h10));
      check("R8 load", tv(8'h23, 8'h05, 8'h17, 8'h03, 8'h08, 8'h30, 8'h10));
      tick_pulse();
      check("R10 one tick no advance", tv(8'h23, 8'h05, 8'h17, 8'h03, 8'h08, 8'h30, 8'h10));
      tick_pulse();
      check("R10 second tick advances", tv(8'h23, 8'h05, 8'h17, 8'h03, 8'h08, 8'h30, 8'h11));
   endtask

   task automatic t_roll_hms();
      load(tv(8'h23, 8'h05, 8'h17, 8'h03, 8'h12, 8'h59, 8'h58));
      one_second();
      check("R1 units roll", tv(8'h23, 8'h05, 8'h17, 8'h03, 8'h12, 8'h59, 8'h59));
      one_second();
      check("R1 R2 minute and hour carry", tv(8'h23, 8'h05, 8'h17, 8'h03, 8'h13, 8'h00, 8'h00));
      load(tv(8'h23, 8'h05, 8'h17, 8'h03, 8'h09, 8'h09, 8'h09));
      one_second();
      check("R11 units 9 carries into tens", tv(8'h23, 8'h05, 8'h17, 8'h03, 8'h09, 8'h09, 8'h10));
   endtask

   task automatic t_century();
      load(tv(8'h99, 8'h12, 8'h31, 8'h06, 8'h23, 8'h59, 8'h59));
      one_second();
      check("R2 R5 R6 century rollover", tv(8'h00, 8'h01, 8'h01, 8'h00, 8'h00, 8'h00, 8'h00));
   endtask

   task automatic t_months();
      for (int m = 1; m <= 12; m++) begin
         int nm, ny;
         nm = (m == 12) ? 1 : m + 1;
         ny = (m == 12) ? 24 : 23;
         load(tv(8'h23, to_bcd(m), to_bcd(mlen(m, 23)), 8'h02, 8'h23, 8'h59, 8'h59));
         one_second();
         check("R3 R5 month end", tv(to_bcd(ny), to_bcd(nm), 8'h01, 8'h03, 8'h00, 8'h00, 8'h00));
      end
   endtask

   task automatic t_leap();
      int yrs[6] = '{0, 10, 23, 24, 96, 98};
      foreach (yrs[k]) begin
         logic [7:0] yb;
         yb = to_bcd(yrs[k]);
         load(tv(yb, 8'h02, 8'h28, 8'h05, 8'h23, 8'h59, 8'h59));
         one_second();
         if (yrs[k] % 4 == 0) begin
            check("R4 leap Feb 29", tv(yb, 8'h02, 8'h29, 8'h06, 8'h00, 8'h00, 8'h00));
            load(tv(yb, 8'h02, 8'h29, 8'h06, 8'h23, 8'h59, 8'h59));
            one_second();
            check("R4 R6 leap to Mar 1 wday wrap", tv(yb, 8'h03, 8'h01, 8'h00, 8'h00, 8'h00, 8'h00));
         end else begin
            check("R4 plain Feb to Mar 1", tv(yb, 8'h03, 8'h01, 8'h06, 8'h00, 8'h00, 8'h00));
         end
      end
   endtask

   task automatic t_stop();
      load(tv(8'h23, 8'h07, 8'h04, 8'h02, 8'h10, 8'h00, 8'h20));
      @(negedge clk); stop = 1'b1;
      for (int i = 0; i < 4 * DIV; i++) tick_pulse();
      check("R7 frozen while stopped", tv(8'h23, 8'h07, 8'h04, 8'h02, 8'h10, 8'h00, 8'h20));
      load(tv(8'h23, 8'h07, 8'h04, 8'h02, 8'h10, 8'h00, 8'h40));
      check("R8 load while stopped", tv(8'h23, 8'h07, 8'h04, 8'h02, 8'h10, 8'h00, 8'h40));
      @(negedge clk); stop = 1'b0;
      tick_pulse();
      check("R7 divider held, one tick no advance", tv(8'h23, 8'h07, 8'h04, 8'h02, 8'h10, 8'h00, 8'h40));
      tick_pulse();
      check("R7 runs after release", tv(8'h23, 8'h07, 8'h04, 8'h02, 8'h10, 8'h00, 8'h41));
   endtask

   task automatic t_comp();
      load(tv(8'h23, 8'h07, 8'h04, 8'h02, 8'h10, 8'h20, 8'h45));
      @(negedge clk); comp = 1'b1;
      @(negedge clk);
      check("R9 round up", tv(8'h23, 8'h07, 8'h04, 8'h02, 8'h10, 8'h21, 8'h00));
      one_second();
      check("R9 held level no repeat", tv(8'h23, 8'h07, 8'h04, 8'h02, 8'h10, 8'h21, 8'h01));
      @(negedge clk); comp = 1'b0;
      load(tv(8'h23, 8'h07, 8'h04, 8'h02, 8'h10, 8'h20, 8'h29));
      comp_edge();
      check("R9 round down", tv(8'h23, 8'h07, 8'h04, 8'h02, 8'h10, 8'h20, 8'h00));
      load(tv(8'h99, 8'h12, 8'h31, 8'h03, 8'h23, 8'h59, 8'h30));
      comp_edge();
      check("R9 round up full carry", tv(8'h00, 8'h01, 8'h01, 8'h04, 8'h00, 8'h00, 8'h00));
   endtask

   task automatic t_priority();
      load(tv(8'h23, 8'h03, 8'h03, 8'h01, 8'h05, 8'h05, 8'h50));
      @(negedge clk);
      {s_year, s_mon, s_mday, s_wday, s_hour, s_min, s_sec} =
         tv(8'h23, 8'h03, 8'h03, 8'h01, 8'h05, 8'h06, 8'h40);
      set = 1'b1; comp = 1'b1;
      @(negedge clk); set = 1'b0; comp = 1'b0;
      check("R12 load beats compensation", tv(8'h23, 8'h03, 8'h03, 8'h01, 8'h05, 8'h06, 8'h40));
      load(tv(8'h23, 8'h03, 8'h03, 8'h01, 8'h05, 8'h05, 8'h10));
      tick_pulse();
      @(negedge clk); comp = 1'b1; tick = 1'b1;
      @(negedge clk); comp = 1'b0; tick = 1'b0;
      check("R12 compensation beats tick", tv(8'h23, 8'h03, 8'h03, 8'h01, 8'h05, 8'h05, 8'h00));
      tick_pulse();
      check("R9 divider cleared by compensation", tv(8'h23, 8'h03, 8'h03, 8'h01, 8'h05, 8'h05, 8'h00));
      tick_pulse();
      check("R10 advance after cleared divider", tv(8'h23, 8'h03, 8'h03, 8'h01, 8'h05, 8'h05, 8'h01));
   endtask

   initial begin
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      t_reset();
      t_prescale();
      t_roll_hms();
      t_century();
      t_months();
      t_leap();
      t_stop();
      t_comp();
      t_priority();
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
   end

   initial begin
      repeat (20000) @(posedge clk);
      checks++;
      fails++;
      $display("FAIL watchdog actual=running expected=done");
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
   end

endmodule